// File: doc/BRIEF.md
# Erase-Before-Program Secret Loader

This block sequences the loading of a secret key into a small nonvolatile store that sits outside it. A host pulses `start` to open a session. The block then holds a bulk-erase strobe for a fixed number of cycles. It does not assume that the erase worked. It reads every word back and compares each one against the blank pattern. Only when all words pass does it accept secret words from the host. It accepts them one at a time through a valid/ready pair and holds each write strobe for a fixed programming time.

Once the last word is written, the host may ask for a verify. The block streams the stored words back in address order, and it does this once only. After that readout, the read strobe to the store stays off until a new complete session has erased and reprogrammed the key.

If any word is not blank after the erase, the session aborts and no write is issued. The block then stays in a fault state that only a reset clears.

Top module: `key_loader`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `erase_fail`, `wr_ready`, `rd_valid`, `mem_erase`, `mem_we` and `mem_re` are all 0.
- R2: A `start` pulse while idle, ready-to-verify or verified drives `mem_erase` high for exactly ERASE_CYCLES (16) consecutive cycles. No `mem_we` or `mem_re` is issued during that time.
- R3: After the erase, every address 0 to NUM_WORDS-1 (8 words) is read through `mem_re` and checked before `wr_ready` or `mem_we` is ever raised. Read data arrive one cycle after the `mem_re` cycle.
- R4: A word that does not read back as all ones (16'hFFFF) ends the check at that word and sets `erase_fail`. After that, no erase, write or read strobe is issued and `start` is ignored. Only reset clears the fault.
- R5: Each word accepted on `wr_valid` while `wr_ready` is high is written to the next ascending address. `mem_we` stays high for WRITE_CYCLES (4) cycles, and address and data are held steady, giving 32 write cycles per session.
- R6: After the last word is written, `done` is 1 and `busy` is 0, and no erase or write strobe is active.
- R7: The first `verify` pulse after programming yields NUM_WORDS `rd_valid` cycles carrying the stored words in address order 0 upward.
- R8: After that readout, later `verify` pulses produce no `mem_re` and no `rd_valid`.
- R9: A new `start` after the verify repeats the full erase, check and program sequence, and it re-enables exactly one more verify.
- R10: `start` while the block is busy and `verify` before programming has completed are ignored. The erase length, the readback and the stored data are unchanged.
- R11: `wr_valid` while `wr_ready` is low is ignored, so no stray word reaches the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Session start strobe |
| wr_valid | input | 1 | Secret word offered by host |
| wr_data | input | WORD_W | Secret word value |
| wr_ready | output | 1 | Block waits for the next secret word |
| verify | input | 1 | One-time readback request |
| rd_valid | output | 1 | Readback word present on rd_data |
| rd_data | output | WORD_W | Readback word, zero when rd_valid is low |
| busy | output | 1 | Erase, check, programming or readout in progress |
| done | output | 1 | Key fully programmed |
| erase_fail | output | 1 | Erase check found a non-blank word (sticky) |
| mem_erase | output | 1 | Bulk-erase strobe to the key store |
| mem_we | output | 1 | Word write strobe to the key store |
| mem_re | output | 1 | Word read strobe to the key store |
| mem_addr | output | ADDR_W | Key store word address |
| mem_wdata | output | WORD_W | Key store write data |
| mem_rdata | input | WORD_W | Key store read data, one cycle after mem_re |

## Verification
The bench models a store in which one word can be made to survive the erase. A loader that trusted the erase, or that checked only part of the array, would then program over a stale word instead of raising `erase_fail` after exactly six reads. The bench also issues a second verify after a good readout, where a leaky design would stream the key again. It injects `start`, `verify` and `wr_valid` while the erase is running, which shows up as a stretched erase, an early readout or a corrupted word order. The length of the erase and of the write pulses is counted, and a stored word that is still valid after a second session must again be readable exactly once.

// File: rtl/key_loader_pkg.sv
package key_loader_pkg;

   typedef enum logic [2:0] {
      KL_IDLE         = 3'd0,
      KL_ERASE        = 3'd1,
      KL_ERASE_CHECK  = 3'd2,
      KL_PROGRAM      = 3'd3,
      KL_READY_VERIFY = 3'd4,
      KL_VERIFIED     = 3'd5,
      KL_FAULT        = 3'd6
   } kl_state_e;

   // Sub-step inside a state: REST waits for the host, ACCESS drives a
   // store strobe, EVAL consumes the word returned by the store.
   typedef enum logic [1:0] {
      PH_REST   = 2'd0,
      PH_ACCESS = 2'd1,
      PH_EVAL   = 2'd2
   } kl_phase_e;

   function automatic int kl_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/kl_cycle_timer.sv
module kl_cycle_timer #(
   parameter int MAX_CYC = 16,
   localparam int TW = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   input  logic          run,
   output logic          expired
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/kl_word_walker.sv
module kl_word_walker #(
   parameter int NUM_WORDS = 8,
   localparam int AW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          last
);

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (clr) begin
         addr_q <= '0;
      end else if (step) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   assign addr = addr_q;
   assign last = (addr_q == AW'(NUM_WORDS - 1));

endmodule

// File: rtl/kl_blank_check.sv
module kl_blank_check #(
   parameter int WORD_W     = 16,
   parameter bit BLANK_HIGH = 1'b1
) (
   input  logic [WORD_W-1:0] word,
   output logic              is_blank
);

   generate
      if (BLANK_HIGH) begin : g_blank_ones
         assign is_blank = &word;
      end else begin : g_blank_zeros
         assign is_blank = ~|word;
      end
   endgenerate

endmodule

// File: rtl/key_loader.sv
module key_loader
   import key_loader_pkg::*;
#(
   parameter int WORD_W       = 16,
   parameter int NUM_WORDS    = 8,
   parameter int ERASE_CYCLES = 16,
   parameter int WRITE_CYCLES = 4,
   parameter bit BLANK_HIGH   = 1'b1,
   localparam int ADDR_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
   localparam int TMR_MAX = kl_max(ERASE_CYCLES, WRITE_CYCLES),
   localparam int TMR_W   = (TMR_MAX > 1) ? $clog2(TMR_MAX) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              verify,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              erase_fail,
   output logic              mem_erase,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata
);

   generate
      if (NUM_WORDS < 2) begin : g_bad_depth
         $error("key_loader: NUM_WORDS must be at least 2");
      end
      if (WORD_W < 1) begin : g_bad_width
         $error("key_loader: WORD_W must be at least 1");
      end
      if (ERASE_CYCLES < 1 || WRITE_CYCLES < 1) begin : g_bad_timing
         $error("key_loader: cycle counts must be at least 1");
      end
   endgenerate

   kl_state_e state_q, state_d;
   kl_phase_e phase_q, phase_d;
   logic [WORD_W-1:0] wdata_q, wdata_d;

   logic             tmr_load, tmr_run, tmr_expired;
   logic [TMR_W-1:0] tmr_val;
   logic             walk_clr, walk_step, walk_last;
   logic [ADDR_W-1:0] walk_addr;
   logic             word_blank;
   logic             start_ok;

   kl_cycle_timer #(.MAX_CYC(TMR_MAX)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .run      (tmr_run),
      .expired  (tmr_expired)
   );

   kl_word_walker #(.NUM_WORDS(NUM_WORDS)) u_walker (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (walk_clr),
      .step  (walk_step),
      .addr  (walk_addr),
      .last  (walk_last)
   );

   kl_blank_check #(.WORD_W(WORD_W), .BLANK_HIGH(BLANK_HIGH)) u_blank (
      .word     (mem_rdata),
      .is_blank (word_blank)
   );

   assign tmr_run = (state_q == KL_ERASE) ||
                    ((state_q == KL_PROGRAM) && (phase_q == PH_ACCESS));

   assign start_ok = (state_q == KL_IDLE) || (state_q == KL_VERIFIED) ||
                     ((state_q == KL_READY_VERIFY) && (phase_q == PH_REST));

   always_comb begin
      state_d   = state_q;
      phase_d   = phase_q;
      wdata_d   = wdata_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      walk_clr  = 1'b0;
      walk_step = 1'b0;

      unique case (state_q)
         KL_ERASE: begin
            if (tmr_expired) begin
               state_d  = KL_ERASE_CHECK;
               phase_d  = PH_ACCESS;
               walk_clr = 1'b1;
            end
         end
         KL_ERASE_CHECK: begin
            if (phase_q == PH_ACCESS) begin
               phase_d = PH_EVAL;
            end else if (!word_blank) begin
               state_d = KL_FAULT;
               phase_d = PH_REST;
            end else if (walk_last) begin
               state_d  = KL_PROGRAM;
               phase_d  = PH_REST;
               walk_clr = 1'b1;
            end else begin
               walk_step = 1'b1;
               phase_d   = PH_ACCESS;
            end
         end
         KL_PROGRAM: begin
            if (phase_q == PH_REST) begin
               if (wr_valid) begin
                  wdata_d  = wr_data;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(WRITE_CYCLES - 1);
                  phase_d  = PH_ACCESS;
               end
            end else if (tmr_expired) begin
               phase_d = PH_REST;
               if (walk_last) begin
                  state_d  = KL_READY_VERIFY;
                  walk_clr = 1'b1;
               end else begin
                  walk_step = 1'b1;
               end
            end
         end
         KL_READY_VERIFY: begin
            if (phase_q == PH_REST) begin
               if (verify) begin
                  walk_clr = 1'b1;
                  phase_d  = PH_ACCESS;
               end
            end else if (phase_q == PH_ACCESS) begin
               phase_d = PH_EVAL;
            end else if (walk_last) begin
               state_d = KL_VERIFIED;
               phase_d = PH_REST;
            end else begin
               walk_step = 1'b1;
               phase_d   = PH_ACCESS;
            end
         end
         KL_IDLE, KL_VERIFIED, KL_FAULT: begin
         end
         default: begin
            state_d = KL_IDLE;
            phase_d = PH_REST;
         end
      endcase

      if (start_ok && start) begin
         state_d  = KL_ERASE;
         phase_d  = PH_REST;
         tmr_load = 1'b1;
         tmr_val  = TMR_W'(ERASE_CYCLES - 1);
         walk_clr = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KL_IDLE;
         phase_q <= PH_REST;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         phase_q <= phase_d;
         wdata_q <= wdata_d;
      end
   end

   assign mem_erase = (state_q == KL_ERASE);
   assign mem_we    = (state_q == KL_PROGRAM) && (phase_q == PH_ACCESS);
   assign mem_re    = ((state_q == KL_ERASE_CHECK) || (state_q == KL_READY_VERIFY)) &&
                      (phase_q == PH_ACCESS);
   assign mem_addr  = walk_addr;
   assign mem_wdata = wdata_q;

   assign wr_ready   = (state_q == KL_PROGRAM) && (phase_q == PH_REST);
   assign rd_valid   = (state_q == KL_READY_VERIFY) && (phase_q == PH_EVAL);
   assign rd_data    = rd_valid ? mem_rdata : '0;
   assign erase_fail = (state_q == KL_FAULT);
   assign done       = (state_q == KL_READY_VERIFY) || (state_q == KL_VERIFIED);
   assign busy       = (state_q == KL_ERASE) || (state_q == KL_ERASE_CHECK) ||
                       (state_q == KL_PROGRAM) ||
                       ((state_q == KL_READY_VERIFY) && (phase_q != PH_REST));

endmodule

// File: rtl/key_loader_chk.sv
module key_loader_chk
   import key_loader_pkg::*;
#(
   parameter int NUM_WORDS    = 8,
   parameter int ERASE_CYCLES = 16,
   parameter int ADDR_W       = 3,
   parameter int WORD_W       = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_erase,
   input logic              mem_we,
   input logic              mem_re,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [WORD_W-1:0] mem_wdata,
   input logic              wr_ready,
   input logic              rd_valid,
   input logic              busy,
   input logic              done,
   input logic              erase_fail,
   input kl_state_e         state_q
);

   logic [31:0] erase_run_q;
   logic [31:0] reads_since_erase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         erase_run_q         <= '0;
         reads_since_erase_q <= '0;
      end else begin
         erase_run_q <= mem_erase ? erase_run_q + 1 : '0;
         if (mem_erase) begin
            reads_since_erase_q <= '0;
         end else if (mem_re) begin
            reads_since_erase_q <= reads_since_erase_q + 1;
         end
      end
   end

   a_r2_erase_alone: assert property (@(posedge clk) disable iff (!rst_n)
      mem_erase |-> (!mem_we && !mem_re));

   a_r2_erase_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_erase) |-> (erase_run_q == ERASE_CYCLES));

   a_r3_write_after_check: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (reads_since_erase_q >= NUM_WORDS));

   a_r4_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      erase_fail |=> erase_fail);

   a_r4_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      erase_fail |-> (!mem_we && !mem_erase && !mem_re && !busy));

   a_r5_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

   a_r5_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> (!mem_we && !mem_re && !mem_erase));

   a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_we && !mem_erase));

   a_r7_read_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(mem_re));

   a_r8_read_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == KL_VERIFIED) |-> (!mem_re && !rd_valid));

endmodule

bind key_loader key_loader_chk #(
   .NUM_WORDS    (NUM_WORDS),
   .ERASE_CYCLES (ERASE_CYCLES),
   .ADDR_W       (ADDR_W),
   .WORD_W       (WORD_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_erase  (mem_erase),
   .mem_we     (mem_we),
   .mem_re     (mem_re),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .wr_ready   (wr_ready),
   .rd_valid   (rd_valid),
   .busy       (busy),
   .done       (done),
   .erase_fail (erase_fail),
   .state_q    (state_q)
);

// File: tb/key_loader_test.sv
`timescale 1ns/1ps
module key_loader_test;

   localparam int NW = 8;
   localparam int WW = 16;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          wr_valid = 1'b0;
   logic [WW-1:0] wr_data = '0;
   logic          wr_ready;
   logic          verify = 1'b0;
   logic          rd_valid;
   logic [WW-1:0] rd_data;
   logic          busy, done, erase_fail;
   logic          mem_erase, mem_we, mem_re;
   logic [AW-1:0] mem_addr;
   logic [WW-1:0] mem_wdata;
   logic [WW-1:0] mem_rdata;

   int vectors = 0;
   int misses  = 0;

   always #2 clk = ~clk;

   key_loader uut (
      .clk(clk), .rst_n(rst_n), .start(start), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_ready(wr_ready), .verify(verify),
      .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
      .erase_fail(erase_fail), .mem_erase(mem_erase), .mem_we(mem_we),
      .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   // Key store model with an optional word that survives erase
   logic [WW-1:0] store [NW];
   logic          stuck_en = 1'b0;
   int            stuck_idx = 0;
   logic [WW-1:0] stuck_val = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NW; i++) store[i] <= WW'(16'h3C00 + i);
         mem_rdata <= '0;
      end else begin
         if (mem_erase)
            for (int i = 0; i < NW; i++)
               store[i] <= (stuck_en && i == stuck_idx) ? stuck_val : '1;
         if (mem_we) store[mem_addr] <= mem_wdata;
         if (mem_re) mem_rdata <= store[mem_addr];
      end
   end

   // Strobe monitor
   int            erase_cnt = 0, we_cnt = 0, re_cnt = 0, rdv_cnt = 0;
   logic [WW-1:0] rd_log [64];

   always @(posedge clk) begin
      if (mem_erase) erase_cnt <= erase_cnt + 1;
      if (mem_we)    we_cnt    <= we_cnt + 1;
      if (mem_re)    re_cnt    <= re_cnt + 1;
      if (rd_valid) begin
         rd_log[rdv_cnt % 64] <= rd_data;
         rdv_cnt <= rdv_cnt + 1;
      end
   end

   logic [WW-1:0] pat [NW];

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      repeat (3) tick;
      rst_n = 1'b1;
      tick;
      check("R1 busy",       32'(busy), 0);
      check("R1 done",       32'(done), 0);
      check("R1 erase_fail", 32'(erase_fail), 0);
      check("R1 strobes",    32'({wr_ready, rd_valid, mem_erase, mem_we, mem_re}), 0);
   endtask

   // One erase/check/program session; poke injects stray strobes mid-erase
   task automatic load_session(input bit poke, input bit expect_fail, input int fail_reads);
      int e0 = erase_cnt, w0 = we_cnt, r0 = re_cnt, v0 = rdv_cnt;
      int k = 0;
      int reads_at_ready = -1;
      int writes_at_ready = -1;
      start = 1'b1;
      tick;
      start = 1'b0;
      for (int c = 0; c < 500; c++) begin
         if (done || erase_fail) break;
         wr_valid = 1'b0;
         start    = 1'b0;
         verify   = 1'b0;
         if (poke && c >= 2 && c <= 4) begin
            start    = 1'b1;
            verify   = 1'b1;
            wr_valid = 1'b1;
            wr_data  = 16'hDEAD;
         end
         if (wr_ready && k < NW) begin
            if (reads_at_ready < 0) begin
               reads_at_ready  = re_cnt - r0;
               writes_at_ready = we_cnt - w0;
            end
            wr_valid = 1'b1;
            wr_data  = pat[k];
            k++;
         end
         tick;
      end
      wr_valid = 1'b0;
      start    = 1'b0;
      verify   = 1'b0;
      tick;
      check("R2 erase cycles", 32'(erase_cnt - e0), 16);
      if (expect_fail) begin
         check("R4 erase_fail set",  32'(erase_fail), 1);
         check("R4 reads before abort", 32'(re_cnt - r0), 32'(fail_reads));
         check("R4 no write",        32'(we_cnt - w0), 0);
      end else begin
         check("R3 reads before ready",  32'(reads_at_ready), 8);
         check("R3 writes before ready", 32'(writes_at_ready), 0);
         check("R5 write cycles",        32'(we_cnt - w0), 32);
         for (int i = 0; i < NW; i++)
            check($sformatf("R5 R11 stored word %0d", i), 32'(store[i]), 32'(pat[i]));
         check("R6 done",  32'(done), 1);
         check("R6 busy",  32'(busy), 0);
         check("R10 no readout during session", 32'(rdv_cnt - v0), 0);
         if (poke) check("R10 reads unchanged by stray verify", 32'(re_cnt - r0), 8);
      end
   endtask

   task automatic do_verify(input string req, input int expect_n);
      int v0 = rdv_cnt, r0 = re_cnt;
      verify = 1'b1;
      tick;
      verify = 1'b0;
      repeat (30) tick;
      check({req, " readout count"}, 32'(rdv_cnt - v0), 32'(expect_n));
      check({req, " read strobes"},  32'(re_cnt - r0),  32'(expect_n));
      if (expect_n == NW)
         for (int i = 0; i < NW; i++)
            check($sformatf("%s word %0d", req, i), 32'(rd_log[(v0 + i) % 64]), 32'(pat[i]));
   endtask

   task automatic t_fault;
      int e0;
      stuck_en  = 1'b1;
      stuck_idx = 5;
      stuck_val = 16'hFFFE;
      do_reset;
      load_session(1'b0, 1'b1, 6);
      e0 = erase_cnt;
      start = 1'b1;
      tick;
      start = 1'b0;
      repeat (20) tick;
      check("R4 start ignored in fault", 32'(erase_cnt - e0), 0);
      check("R4 fault persists", 32'(erase_fail), 1);
      stuck_en = 1'b0;
      do_reset;
      check("R4 reset clears fault", 32'(erase_fail), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      misses++;
      $display("FAIL watchdog expired R1 actual=hung expected=finished");
      summary;
      $finish;
   end

   initial begin
      do_reset;
      do_verify("R10 verify before programming", 0);

      for (int i = 0; i < NW; i++) pat[i] = WW'(16'hA5C3 ^ (i * 16'h1111));
      load_session(1'b1, 1'b0, 0);
      do_verify("R7 first verify", NW);
      do_verify("R8 second verify", 0);
      check("R8 done held", 32'(done), 1);

      for (int i = 0; i < NW; i++) pat[i] = WW'((i * 16'h0F0F) + 16'h0102);
      load_session(1'b0, 1'b0, 0);
      do_verify("R9 verify after new session", NW);
      do_verify("R9 R8 repeat verify", 0);

      t_fault;

      summary;
      $finish;
   end

endmodule